// File: doc/BRIEF.md
# Privileged Status Register File

This block keeps the machine status word and the interrupt pending, enable and delegation words for a core with user, supervisor and machine privilege levels. An execute stage presents a 12-bit register address, a read strobe, a write strobe, write data and the current privilege. The block answers in the same cycle with read data and an access-fault flag. Accepted writes land on the next rising clock edge.

Every write goes through a per-field legality mask, so software can never store an encoding the core does not support. The previous-privilege field of the machine status keeps its old value when the written code is the reserved one. The translation-mode field keeps its old value when the written mode is not in a parameterised legal set. The supervisor status and the supervisor interrupt words are filtered views of the machine words, not separate storage.

The summary-dirty bit is derived from the two dirty fields. The current status, pending, enable and delegation words are always driven to the trap and interrupt logic. Two live sources feed the pending word: a timer level and a host message word.

Top module: `priv_csr_file`

## Requirements
- R1: An access (read or write strobe) raises `csr_illegal_o` in the same cycle when address bits [9:8] are numerically greater than `cur_priv_i` (user 0, supervisor 1, machine 3).
- R2: A write raises `csr_illegal_o` when address bits [11:10] equal 3.
- R3: A faulting access changes no state and returns zero read data. An address that maps to no register (any address other than 0x300, 0x303, 0x304, 0x344, 0x100, 0x104, 0x144) reads as zero without a fault, and writes to it change nothing.
- R4: A write to the machine status (0x300) changes only bit 1 (supervisor enable), bit 3 (machine enable), bit 5 (supervisor previous enable), bit 7 (machine previous enable), bit 8 (supervisor previous privilege), bit 17 (modify-privilege), bits 14:13 (FP dirty state), and bits 16:15 (extension dirty state) only when `HAS_EXT` is 1. All other bits read as zero, apart from the conditional fields of R5, R6 and R7.
- R5: The machine previous-privilege field, bits 12:11, takes the written value only when that value is 0, 1 or 3. A written 2 leaves the field unchanged.
- R6: The translation-mode field, bits 23:19, takes the written value only when bit `value` of `VM_LEGAL` is 1 (default legal modes are 0 and 8). Otherwise the field is unchanged.
- R7: The top status bit (bit XLEN-1) reads as 1 exactly when bits 14:13 or bits 16:15 equal 3.
- R8: A supervisor status read (0x100) returns the machine status masked to bits 1, 5, 8, 14:13 and 16:15, plus the top-bit summary of R7.
- R9: A supervisor status write changes only bits 1, 5, 8, 14:13 and 16:15 of the machine status.
- R10: In the machine pending word (0x344), bits 1 (S-soft), 3 (M-soft) and 5 (S-timer) are software-writable. Bit 7 (M-timer) follows `timer_irq_i`, bit 9 (host) is 1 exactly when `host_msg_i` is nonzero, and all other bits are zero.
- R11: A supervisor pending write (0x144) changes only bit 1 of the pending word. A supervisor pending read returns the pending word masked to bits 1 and 5.
- R12: The machine enable word (0x304) stores bits 1, 3, 5, 7 and 9. A supervisor enable write (0x104) changes only bits 1 and 5, and a supervisor enable read returns only bits 1 and 5.
- R13: The interrupt delegation word (0x303) stores only bits 1 and 5.
- R14: All stored state is zero after reset. A write takes effect on the rising edge that samples the strobe, and no port changes before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr_i | input | 12 | Register address |
| csr_rd_i | input | 1 | Read strobe |
| csr_wr_i | input | 1 | Write strobe |
| csr_wdata_i | input | XLEN | Write data |
| cur_priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| timer_irq_i | input | 1 | Machine timer interrupt level |
| host_msg_i | input | XLEN | Host message word; nonzero raises host pending |
| csr_rdata_o | output | XLEN | Read data, zero on fault or unmapped address |
| csr_illegal_o | output | 1 | Access fault |
| status_o | output | XLEN | Machine status word including summary bit |
| pend_o | output | XLEN | Interrupt pending word |
| enab_o | output | XLEN | Interrupt enable word |
| deleg_o | output | XLEN | Interrupt delegation word |

## Verification
A stored field that escapes its mask shows up on `status_o`, `pend_o`, `enab_o` or `deleg_o` on the edge right after the offending write. It stays visible there until another write overwrites it, so the bench reads every word back right after each write. A wrong summary bit or a wrong supervisor mask appears combinationally on `csr_rdata_o` in the same cycle as the read. A fault decision that is too loose shows up as a state change on the next edge. A fault decision that is too strict shows up at once as a raised `csr_illegal_o`.

// File: rtl/priv_csr_pkg.sv
`timescale 1ns/1ps
package priv_csr_pkg;

   typedef enum logic [1:0] {
      PRIV_U = 2'd0,
      PRIV_S = 2'd1,
      PRIV_H = 2'd2,
      PRIV_M = 2'd3
   } priv_e;

   // register addresses; bits [9:8] carry the lowest privilege allowed
   localparam logic [11:0] A_MSTATUS = 12'h300;
   localparam logic [11:0] A_MIDELEG = 12'h303;
   localparam logic [11:0] A_MIE     = 12'h304;
   localparam logic [11:0] A_MIP     = 12'h344;
   localparam logic [11:0] A_SSTATUS = 12'h100;
   localparam logic [11:0] A_SIE     = 12'h104;
   localparam logic [11:0] A_SIP     = 12'h144;

   // status field positions
   localparam int ST_SIE    = 1;
   localparam int ST_MIE    = 3;
   localparam int ST_SPIE   = 5;
   localparam int ST_MPIE   = 7;
   localparam int ST_SPP    = 8;
   localparam int ST_MPP_LO = 11;
   localparam int ST_FS_LO  = 13;
   localparam int ST_XS_LO  = 15;
   localparam int ST_MPRV   = 17;
   localparam int ST_VM_LO  = 19;
   localparam int VM_W      = 5;

   localparam logic [31:0] MSK_MPP = 32'h3 << ST_MPP_LO;
   localparam logic [31:0] MSK_FS  = 32'h3 << ST_FS_LO;
   localparam logic [31:0] MSK_XS  = 32'h3 << ST_XS_LO;
   localparam logic [31:0] MSK_VM  = 32'h1F << ST_VM_LO;
   localparam logic [31:0] MSK_M_BASE = (32'h1 << ST_SIE) | (32'h1 << ST_MIE)
                                      | (32'h1 << ST_SPIE) | (32'h1 << ST_MPIE)
                                      | (32'h1 << ST_SPP) | (32'h1 << ST_MPRV)
                                      | MSK_FS;
   localparam logic [31:0] MSK_S_VIEW = (32'h1 << ST_SIE) | (32'h1 << ST_SPIE)
                                      | (32'h1 << ST_SPP) | MSK_FS | MSK_XS;

   // interrupt bit positions
   localparam int IRQ_SSOFT  = 1;
   localparam int IRQ_HSOFT  = 2;
   localparam int IRQ_MSOFT  = 3;
   localparam int IRQ_STIMER = 5;
   localparam int IRQ_HTIMER = 6;
   localparam int IRQ_MTIMER = 7;
   localparam int IRQ_COP    = 8;
   localparam int IRQ_HOST   = 9;

   localparam logic [31:0] IRQ_SW_M  = (32'h1 << IRQ_SSOFT) | (32'h1 << IRQ_MSOFT)
                                     | (32'h1 << IRQ_STIMER);
   localparam logic [31:0] IRQ_SW_S  = 32'h1 << IRQ_SSOFT;
   localparam logic [31:0] IRQ_S_SET = (32'h1 << IRQ_SSOFT) | (32'h1 << IRQ_STIMER);
   localparam logic [31:0] IRQ_IMPL  = IRQ_SW_M | (32'h1 << IRQ_MTIMER) | (32'h1 << IRQ_HOST);

endpackage

// File: rtl/csr_access_guard.sv
`timescale 1ns/1ps
module csr_access_guard
   import priv_csr_pkg::*;
#(
   parameter int AW = 12
) (
   input  logic [AW-1:0] addr_i,
   input  logic          rd_i,
   input  logic          wr_i,
   input  logic [1:0]    priv_i,
   output logic          fault_o,
   output logic          wr_ok_o
);
   localparam int LVL_LO = AW - 4;
   localparam int RO_LO  = AW - 2;

   logic too_low;
   logic read_only;

   always_comb begin
      too_low   = addr_i[LVL_LO +: 2] > priv_i;
      read_only = addr_i[RO_LO +: 2] == 2'b11;
      fault_o   = (rd_i | wr_i) & (too_low | (wr_i & read_only));
      wr_ok_o   = wr_i & ~fault_o;
   end
endmodule

// File: rtl/csr_status_reg.sv
`timescale 1ns/1ps
module csr_status_reg
   import priv_csr_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter bit          HAS_EXT  = 1'b1,
   parameter logic [31:0] VM_LEGAL = 32'h0000_0101
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            m_we_i,
   input  logic            s_we_i,
   input  logic [XLEN-1:0] wdata_i,
   output logic [XLEN-1:0] status_o,
   output logic [XLEN-1:0] sview_o
);
   localparam logic [XLEN-1:0] SD_BIT = {1'b1, {(XLEN-1){1'b0}}};
   localparam logic [XLEN-1:0] M_BASE = XLEN'(MSK_M_BASE);
   localparam logic [XLEN-1:0] M_MPP  = XLEN'(MSK_MPP);
   localparam logic [XLEN-1:0] M_VM   = XLEN'(MSK_VM);
   localparam logic [XLEN-1:0] M_XS   = XLEN'(MSK_XS);
   localparam logic [XLEN-1:0] M_SV   = XLEN'(MSK_S_VIEW);

   logic [XLEN-1:0] xs_allow;
   logic [XLEN-1:0] st_q, st_d;
   logic [XLEN-1:0] m_mask, s_mask, impl_all;
   logic            mpp_ok, vm_ok, dirty;

   generate
      if (HAS_EXT) begin : g_ext
         assign xs_allow = M_XS;
      end else begin : g_no_ext
         assign xs_allow = '0;
      end
   endgenerate

   assign impl_all = M_BASE | M_MPP | M_VM | xs_allow;

   always_comb begin
      mpp_ok = wdata_i[ST_MPP_LO +: 2] != 2'b10;
      vm_ok  = VM_LEGAL[wdata_i[ST_VM_LO +: VM_W]];
      m_mask = M_BASE | xs_allow | (mpp_ok ? M_MPP : '0) | (vm_ok ? M_VM : '0);
      s_mask = M_SV & (M_BASE | xs_allow);
      st_d   = st_q;
      if (m_we_i)
         st_d = (st_q & ~m_mask) | (wdata_i & m_mask);
      else if (s_we_i)
         st_d = (st_q & ~s_mask) | (wdata_i & s_mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end

   assign dirty    = (st_q[ST_FS_LO +: 2] == 2'b11) | (st_q[ST_XS_LO +: 2] == 2'b11);
   assign status_o = st_q | (dirty ? SD_BIT : '0);
   assign sview_o  = (st_q & M_SV) | (dirty ? SD_BIT : '0);

   // R4: nothing outside the implemented fields is ever stored
   assert_impl_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q & ~impl_all) == '0);

   // R5: the reserved previous-privilege code never lands
   assert_mpp_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (m_we_i && wdata_i[ST_MPP_LO +: 2] == 2'b10) |=> $stable(st_q[ST_MPP_LO +: 2]));

   // R9: supervisor writes leave machine-only fields alone
   assert_sview_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (s_we_i && !m_we_i) |=> ($stable(st_q[ST_MIE]) && $stable(st_q[ST_MPIE])
                              && $stable(st_q[ST_MPP_LO +: 2]) && $stable(st_q[ST_MPRV])));

   // R14: state only moves on a write
   assert_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_we_i || s_we_i) |=> $stable(st_q));
endmodule

// File: rtl/csr_irq_regs.sv
`timescale 1ns/1ps
module csr_irq_regs
   import priv_csr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mip_we_i,
   input  logic            sip_we_i,
   input  logic            mie_we_i,
   input  logic            sie_we_i,
   input  logic            dlg_we_i,
   input  logic [XLEN-1:0] wdata_i,
   input  logic            timer_i,
   input  logic            host_nz_i,
   output logic [XLEN-1:0] pend_o,
   output logic [XLEN-1:0] enab_o,
   output logic [XLEN-1:0] deleg_o
);
   localparam logic [XLEN-1:0] SW_M  = XLEN'(IRQ_SW_M);
   localparam logic [XLEN-1:0] SW_S  = XLEN'(IRQ_SW_S);
   localparam logic [XLEN-1:0] S_SET = XLEN'(IRQ_S_SET);
   localparam logic [XLEN-1:0] IMPL  = XLEN'(IRQ_IMPL);

   logic [XLEN-1:0] pend_q, enab_q, dlg_q;
   logic [XLEN-1:0] pend_d, enab_d, dlg_d;

   function automatic logic [XLEN-1:0] merge(input logic [XLEN-1:0] old_v,
                                             input logic [XLEN-1:0] new_v,
                                             input logic [XLEN-1:0] msk);
      merge = (old_v & ~msk) | (new_v & msk);
   endfunction

   always_comb begin
      pend_d = pend_q;
      enab_d = enab_q;
      dlg_d  = dlg_q;
      if (mip_we_i)      pend_d = merge(pend_q, wdata_i, SW_M);
      else if (sip_we_i) pend_d = merge(pend_q, wdata_i, SW_S);
      if (mie_we_i)      enab_d = merge(enab_q, wdata_i, IMPL);
      else if (sie_we_i) enab_d = merge(enab_q, wdata_i, S_SET);
      if (dlg_we_i)      dlg_d  = merge(dlg_q, wdata_i, S_SET);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         enab_q <= '0;
         dlg_q  <= '0;
      end else begin
         pend_q <= pend_d;
         enab_q <= enab_d;
         dlg_q  <= dlg_d;
      end
   end

   always_comb begin
      pend_o = pend_q;
      pend_o[IRQ_MTIMER] = timer_i;
      pend_o[IRQ_HOST]   = host_nz_i;
   end
   assign enab_o  = enab_q;
   assign deleg_o = dlg_q;

   // R11: supervisor pending writes touch only the S-soft bit
   assert_sip_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sip_we_i && !mip_we_i) |=> ($stable(pend_q[IRQ_MSOFT]) && $stable(pend_q[IRQ_STIMER])));

   // R12: supervisor enable writes leave machine bits alone
   assert_sie_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (sie_we_i && !mie_we_i) |=> ($stable(enab_q[IRQ_MSOFT]) && $stable(enab_q[IRQ_MTIMER])
                                   && $stable(enab_q[IRQ_HOST])));

   // R13: delegation holds supervisor bits only
   assert_deleg_set_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (dlg_q & ~S_SET) == '0);

   // R10: the M-timer bit is never taken from software
   assert_mtimer_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[IRQ_MTIMER] == 1'b0);
endmodule

// File: rtl/priv_csr_file.sv
`timescale 1ns/1ps
module priv_csr_file
   import priv_csr_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter bit          HAS_EXT  = 1'b1,
   parameter logic [31:0] VM_LEGAL = 32'h0000_0101
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [11:0]     csr_addr_i,
   input  logic            csr_rd_i,
   input  logic            csr_wr_i,
   input  logic [XLEN-1:0] csr_wdata_i,
   input  logic [1:0]      cur_priv_i,
   input  logic            timer_irq_i,
   input  logic [XLEN-1:0] host_msg_i,
   output logic [XLEN-1:0] csr_rdata_o,
   output logic            csr_illegal_o,
   output logic [XLEN-1:0] status_o,
   output logic [XLEN-1:0] pend_o,
   output logic [XLEN-1:0] enab_o,
   output logic [XLEN-1:0] deleg_o
);
   localparam int AW = 12;
   localparam logic [XLEN-1:0] S_SET = XLEN'(IRQ_S_SET);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("priv_csr_file: XLEN must be 32 or 64");
      end
   endgenerate

   logic            wr_ok;
   logic [XLEN-1:0] sview;
   logic            we_mst, we_sst, we_mip, we_sip, we_mie, we_sie, we_dlg;

   csr_access_guard #(.AW(AW)) guard_i (
      .addr_i  (csr_addr_i),
      .rd_i    (csr_rd_i),
      .wr_i    (csr_wr_i),
      .priv_i  (cur_priv_i),
      .fault_o (csr_illegal_o),
      .wr_ok_o (wr_ok)
   );

   always_comb begin
      we_mst = wr_ok && csr_addr_i == A_MSTATUS;
      we_sst = wr_ok && csr_addr_i == A_SSTATUS;
      we_mip = wr_ok && csr_addr_i == A_MIP;
      we_sip = wr_ok && csr_addr_i == A_SIP;
      we_mie = wr_ok && csr_addr_i == A_MIE;
      we_sie = wr_ok && csr_addr_i == A_SIE;
      we_dlg = wr_ok && csr_addr_i == A_MIDELEG;
   end

   csr_status_reg #(.XLEN(XLEN), .HAS_EXT(HAS_EXT), .VM_LEGAL(VM_LEGAL)) status_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .m_we_i   (we_mst),
      .s_we_i   (we_sst),
      .wdata_i  (csr_wdata_i),
      .status_o (status_o),
      .sview_o  (sview)
   );

   csr_irq_regs #(.XLEN(XLEN)) irq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mip_we_i  (we_mip),
      .sip_we_i  (we_sip),
      .mie_we_i  (we_mie),
      .sie_we_i  (we_sie),
      .dlg_we_i  (we_dlg),
      .wdata_i   (csr_wdata_i),
      .timer_i   (timer_irq_i),
      .host_nz_i (|host_msg_i),
      .pend_o    (pend_o),
      .enab_o    (enab_o),
      .deleg_o   (deleg_o)
   );

   always_comb begin
      csr_rdata_o = '0;
      if (!csr_illegal_o) begin
         case (csr_addr_i)
            A_MSTATUS: csr_rdata_o = status_o;
            A_SSTATUS: csr_rdata_o = sview;
            A_MIP:     csr_rdata_o = pend_o;
            A_SIP:     csr_rdata_o = pend_o & S_SET;
            A_MIE:     csr_rdata_o = enab_o;
            A_SIE:     csr_rdata_o = enab_o & S_SET;
            A_MIDELEG: csr_rdata_o = deleg_o;
            default:   csr_rdata_o = '0;
         endcase
      end
   end

   // R1: privilege level in the address is enforced
   assert_priv_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ((csr_rd_i || csr_wr_i) && csr_addr_i[9:8] > cur_priv_i) |-> csr_illegal_o);

   // R2: writes to the read-only quadrant fault
   assert_ro_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr_i && csr_addr_i[11:10] == 2'b11) |-> csr_illegal_o);

   // R3: a faulting write leaves every stored word unchanged
   assert_fault_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr_i && csr_illegal_o) |=> ($stable(status_o) && $stable(enab_o) && $stable(deleg_o)));

   // R3: faulting reads return zero
   assert_fault_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      csr_illegal_o |-> csr_rdata_o == '0);
endmodule

// File: tb/priv_csr_file_tb.sv
`timescale 1ns/1ps
module priv_csr_file_tb_top;
   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [11:0]     addr = '0;
   logic            rd = 1'b0, wr = 1'b0;
   logic [XLEN-1:0] wdata = '0;
   logic [1:0]      priv = 2'd3;
   logic            timer = 1'b0;
   logic [XLEN-1:0] host = '0;
   logic [XLEN-1:0] rdata, status, pend, enab, deleg;
   logic            illegal;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   priv_csr_file dut_i (
      .clk(clk), .rst_n(rst_n), .csr_addr_i(addr), .csr_rd_i(rd), .csr_wr_i(wr),
      .csr_wdata_i(wdata), .cur_priv_i(priv), .timer_irq_i(timer), .host_msg_i(host),
      .csr_rdata_o(rdata), .csr_illegal_o(illegal), .status_o(status),
      .pend_o(pend), .enab_o(enab), .deleg_o(deleg)
   );

   task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // write at a falling edge, strobe held across one rising edge
   task automatic wr_csr(input logic [11:0] a, input logic [XLEN-1:0] d, input logic [1:0] p);
      @(negedge clk);
      addr = a; wdata = d; priv = p; wr = 1'b1; rd = 1'b0;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_csr(input logic [11:0] a, input logic [1:0] p,
                         output logic [XLEN-1:0] d, output logic f);
      @(negedge clk);
      addr = a; priv = p; rd = 1'b1; wr = 1'b0;
      #1;
      d = rdata; f = illegal;
      rd = 1'b0;
   endtask

   logic [XLEN-1:0] v;
   logic            f;

   task automatic t_reset();
      rd_csr(12'h300, 2'd3, v, f);
      check("R14 reset status", v, 32'h0);
      check("R14 reset enable", enab, 32'h0);
      check("R14 reset deleg", deleg, 32'h0);
      check("R14 reset pend", pend, 32'h0);
   endtask

   task automatic t_priv();
      rd_csr(12'h300, 2'd1, v, f);
      check("R1 sup reads machine", {31'b0, f}, 32'h1);
      rd_csr(12'h100, 2'd0, v, f);
      check("R1 user reads supervisor", {31'b0, f}, 32'h1);
      rd_csr(12'h100, 2'd1, v, f);
      check("R1 sup reads supervisor", {31'b0, f}, 32'h0);
   endtask

   task automatic t_readonly();
      @(negedge clk);
      addr = 12'hC00; wdata = 32'hFFFF_FFFF; priv = 2'd3; wr = 1'b1;
      #1;
      check("R2 write read-only space", {31'b0, illegal}, 32'h1);
      @(negedge clk);
      wr = 1'b0;
      rd_csr(12'hC00, 2'd3, v, f);
      check("R3 read unmapped fault", {31'b0, f}, 32'h0);
      check("R3 read unmapped data", v, 32'h0);
      wr_csr(12'h7C0, 32'hFFFF_FFFF, 2'd3);
      check("R3 unmapped write status", status, 32'h0);
      check("R3 unmapped write enable", enab, 32'h0);
   endtask

   task automatic t_fault_write();
      wr_csr(12'h300, 32'hFFFF_FFFF, 2'd1);
      rd_csr(12'h300, 2'd3, v, f);
      check("R3 faulting write ignored", v, 32'h0);
   endtask

   task automatic t_mstatus_mask();
      wr_csr(12'h300, 32'hFFFF_FFFF, 2'd3);
      rd_csr(12'h300, 2'd3, v, f);
      check("R4 masked write all ones", v, 32'h8003_F9AA);
   endtask

   task automatic t_mpp();
      wr_csr(12'h300, 32'h0000_1000, 2'd3);
      check("R5 reserved mode kept", status, 32'h0000_1800);
      wr_csr(12'h300, 32'h0000_0800, 2'd3);
      check("R5 supervisor mode taken", status, 32'h0000_0800);
   endtask

   task automatic t_vm();
      wr_csr(12'h300, 32'h0040_0000, 2'd3);
      check("R6 legal mode taken", status, 32'h0040_0000);
      wr_csr(12'h300, 32'h0018_0000, 2'd3);
      check("R6 illegal mode kept", status, 32'h0040_0000);
   endtask

   task automatic t_sd();
      wr_csr(12'h300, 32'h0000_6000, 2'd3);
      check("R7 fp dirty sets top", status, 32'h8000_6000);
      wr_csr(12'h300, 32'h0001_8000, 2'd3);
      check("R7 ext dirty sets top", status, 32'h8001_8000);
      wr_csr(12'h300, 32'h0000_2000, 2'd3);
      check("R7 partial dirty clears top", status, 32'h0000_2000);
   endtask

   task automatic t_sview();
      wr_csr(12'h300, 32'hFFFF_FFFF, 2'd3);
      rd_csr(12'h100, 2'd1, v, f);
      check("R8 supervisor view read", v, 32'h8001_E122);
      wr_csr(12'h100, 32'h0, 2'd1);
      rd_csr(12'h300, 2'd3, v, f);
      check("R9 supervisor write scope", v, 32'h0002_1888);
   endtask

   task automatic t_pending();
      wr_csr(12'h344, 32'hFFFF_FFFF, 2'd3);
      check("R10 software pending bits", pend, 32'h0000_002A);
      @(negedge clk);
      timer = 1'b1; host = 32'h5;
      rd_csr(12'h344, 2'd3, v, f);
      check("R10 live timer and host", v, 32'h0000_02AA);
      wr_csr(12'h344, 32'h0, 2'd3);
      check("R10 software clear keeps live", pend, 32'h0000_0280);
      @(negedge clk);
      timer = 1'b0; host = 32'h0;
      #1;
      check("R10 live sources drop", pend, 32'h0);
   endtask

   task automatic t_sip();
      wr_csr(12'h344, 32'h0000_0028, 2'd3);
      wr_csr(12'h144, 32'hFFFF_FFFF, 2'd1);
      check("R11 sup pending sets soft only", pend, 32'h0000_002A);
      rd_csr(12'h144, 2'd1, v, f);
      check("R11 sup pending read mask", v, 32'h0000_0022);
      wr_csr(12'h144, 32'h0, 2'd1);
      check("R11 sup pending clear", pend, 32'h0000_0028);
   endtask

   task automatic t_enable();
      wr_csr(12'h304, 32'hFFFF_FFFF, 2'd3);
      check("R12 machine enable set", enab, 32'h0000_02AA);
      wr_csr(12'h104, 32'h0, 2'd1);
      check("R12 sup enable clear scope", enab, 32'h0000_0288);
      rd_csr(12'h104, 2'd1, v, f);
      check("R12 sup enable read", v, 32'h0);
      wr_csr(12'h104, 32'hFFFF_FFFF, 2'd1);
      rd_csr(12'h104, 2'd1, v, f);
      check("R12 sup enable set", v, 32'h0000_0022);
   endtask

   task automatic t_deleg();
      wr_csr(12'h303, 32'hFFFF_FFFF, 2'd3);
      rd_csr(12'h303, 2'd3, v, f);
      check("R13 delegation read", v, 32'h0000_0022);
      check("R13 delegation port", deleg, 32'h0000_0022);
   endtask

   task automatic t_timing();
      wr_csr(12'h303, 32'h0, 2'd3);
      @(negedge clk);
      addr = 12'h303; wdata = 32'h2; priv = 2'd3; wr = 1'b1;
      #1;
      check("R14 no change before edge", deleg, 32'h0);
      @(negedge clk);
      wr = 1'b0;
      check("R14 change after edge", deleg, 32'h2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_priv();
      t_readonly();
      t_fault_write();
      t_mstatus_mask();
      t_mpp();
      t_vm();
      t_sd();
      t_sview();
      t_pending();
      t_sip();
      t_enable();
      t_deleg();
      t_timing();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule